// File: doc/BRIEF.md
# Configurable DRAM Address Mapper

This block turns a 32-bit bus byte address into the bank, row and column coordinates of one DRAM device. A single 32-bit configuration word sets which part of the address space belongs to the device. The same word sets how many column, row and bank bits the device has, and whether the bank bits sit above the row bits or between the row and column bits. Software loads the word through a one-cycle write strobe. From then on every request is decoded against the new setting.

A request is one address with a valid strobe. One clock later the block presents a registered valid flag, a chip-hit flag and the three coordinates. The chip-hit flag comes from a mask-and-compare on the upper address byte. The coordinates come from the in-device offset, after the bus byte-lane bits are discarded. An illegal code in the configuration word raises an error flag. While the flag is up, the block reports no hits.

Top module: `dram_addr_map`

## Requirements
- R1: After reset the configuration word is 0x28F8_0312. This gives base 0x28, mask 0xF8, linear order, 10 column bits, 13 row bits and 2 bank bits. So addresses 0x2800_0000 to 0x2FFF_FFFF hit and the addresses just outside that range miss.
- R2: The device is hit when (address[31:24] AND word[23:16]) equals word[31:24]. A base bit that lies outside the mask therefore prevents any hit.
- R3: The offset is the address with every upper-byte bit whose mask bit is 1 forced to zero. Only the offset feeds the coordinates, and they are produced whether or not the device is hit.
- R4: Address bits [1:0] are discarded. The column is the next C bits, where C = 7 + word[11:8] for codes 0 to 3.
- R5: When word[15:12] = 0 (linear order), the row follows the column and the bank lies above the row.
- R6: When word[15:12] = 1 (interleaved order), the bank follows the column and the row lies above the bank.
- R7: The row width is 12 + word[7:4] and the bank width is word[3:0], for codes 0 to 3. A bank code of 0 means there are no bank bits.
- R8: A mapping code above 1, or any width code above 3, drives cfg_error_o high. Any request decoded under such a word returns hit 0 and all-zero coordinates.
- R9: out_valid_o is high exactly one cycle after an accepted request, together with that request's results. A cycle with no request gives out_valid_o = 0 and hit_o = 0 one cycle later, and leaves the coordinates unchanged.
- R10: A configuration write takes effect at the clock edge where it is strobed. A request in the same cycle as the write is decoded with the previous word.
- R11: Coordinate output bits above the configured width are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word to load |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Request byte address |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| hit_o | output | 1 | Request falls inside this device's window |
| bank_o | output | 3 | Bank coordinate |
| row_o | output | 15 | Row coordinate |
| col_o | output | 10 | Column coordinate |
| cfg_error_o | output | 1 | Current configuration word holds an illegal code |

## Verification
A corrupted configuration field shows up at the ports in the first request after it. The wrong field may change the hit decision, move bits between the bank, row and column outputs, or set cfg_error_o, which changes as soon as the register does. A slicing fault in one mapping order or at one width only shows when that order and width are used. For that reason the sweep covers every legal width and order combination, using addresses with all offset bits set. A pipeline fault appears as a valid, hit or coordinate value one cycle out of place, or as coordinates that fail to hold through idle cycles.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;

  typedef struct packed {
    logic [7:0] base;
    logic [7:0] mask;
    logic [3:0] map;
    logic [3:0] col;
    logic [3:0] row;
    logic [3:0] bank;
  } map_cfg_t;

  typedef enum logic [3:0] {
    MAP_LINEAR     = 4'd0,
    MAP_INTERLEAVE = 4'd1
  } map_mode_e;

  localparam int unsigned CODE_MAX = 3;

endpackage

// File: rtl/dram_map_cfg.sv
module dram_map_cfg
  import dram_map_pkg::*;
#(
  parameter logic [31:0] RST_CFG = 32'h28F8_0312,
  parameter int unsigned COL_MIN = 7,
  parameter int unsigned ROW_MIN = 12,
  parameter int unsigned CB_W    = 4,
  parameter int unsigned RB_W    = 4,
  parameter int unsigned BB_W    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [31:0]     wdata_i,
  output map_cfg_t        cfg_o,
  output logic [CB_W-1:0] col_bits_o,
  output logic [RB_W-1:0] row_bits_o,
  output logic [BB_W-1:0] bank_bits_o,
  output logic            interleave_o,
  output logic            err_o
);

  map_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= map_cfg_t'(RST_CFG);
    else if (we_i) cfg_q <= map_cfg_t'(wdata_i);
  end

  assign cfg_o        = cfg_q;
  assign interleave_o = (cfg_q.map == 4'(MAP_INTERLEAVE));
  assign err_o        = (cfg_q.map  > 4'(MAP_INTERLEAVE)) ||
                        (cfg_q.col  > 4'(CODE_MAX)) ||
                        (cfg_q.row  > 4'(CODE_MAX)) ||
                        (cfg_q.bank > 4'(CODE_MAX));

  // width = minimum + code; reserved codes are flagged by err_o
  assign col_bits_o  = CB_W'(COL_MIN) + CB_W'(cfg_q.col[1:0]);
  assign row_bits_o  = RB_W'(ROW_MIN) + RB_W'(cfg_q.row[1:0]);
  assign bank_bits_o = BB_W'(cfg_q.bank[1:0]);

  assert_write_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_q == map_cfg_t'($past(wdata_i))));

endmodule

// File: rtl/dram_map_match.sv
module dram_map_match #(
  parameter int unsigned BASE_W = 8
) (
  input  logic [BASE_W-1:0] addr_hi_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [BASE_W-1:0] mask_i,
  output logic              hit_o
);

  logic [BASE_W-1:0] bit_eq;

  for (genvar i = 0; i < BASE_W; i++) begin : g_cmp
    assign bit_eq[i] = ((addr_hi_i[i] & mask_i[i]) == base_i[i]);
  end

  assign hit_o = &bit_eq;

endmodule

// File: rtl/dram_map_slice.sv
module dram_map_slice #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BYTE_BITS = 2,
  parameter int unsigned BASE_W    = 8,
  parameter int unsigned COL_MAX   = 10,
  parameter int unsigned ROW_MAX   = 15,
  parameter int unsigned BANK_MAX  = 3,
  parameter int unsigned CB_W      = 4,
  parameter int unsigned RB_W      = 4,
  parameter int unsigned BB_W      = 2
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [BASE_W-1:0]   mask_i,
  input  logic [CB_W-1:0]     col_bits_i,
  input  logic [RB_W-1:0]     row_bits_i,
  input  logic [BB_W-1:0]     bank_bits_i,
  input  logic                interleave_i,
  output logic [BANK_MAX-1:0] bank_o,
  output logic [ROW_MAX-1:0]  row_o,
  output logic [COL_MAX-1:0]  col_o
);

  localparam int unsigned SRC_W = ADDR_W - BYTE_BITS;
  localparam int unsigned LOW_W = ADDR_W - BASE_W;

  logic [ADDR_W-1:0]   offset;
  logic [SRC_W-1:0]    src;
  logic [SRC_W-1:0]    rest;
  logic [COL_MAX-1:0]  col_msk;
  logic [ROW_MAX-1:0]  row_msk;
  logic [BANK_MAX-1:0] bank_msk;
  logic [ROW_MAX-1:0]  row_lin, row_il;
  logic [BANK_MAX-1:0] bank_lin, bank_il;

  // chip-select bits are not part of the in-device offset
  assign offset = {addr_i[ADDR_W-1 -: BASE_W] & ~mask_i, addr_i[LOW_W-1:0]};
  assign src    = SRC_W'(offset >> BYTE_BITS);

  assign col_msk  = ~({COL_MAX{1'b1}}  << col_bits_i);
  assign row_msk  = ~({ROW_MAX{1'b1}}  << row_bits_i);
  assign bank_msk = ~({BANK_MAX{1'b1}} << bank_bits_i);

  assign col_o = COL_MAX'(src) & col_msk;
  assign rest  = src >> col_bits_i;

  assign row_lin  = ROW_MAX'(rest) & row_msk;
  assign bank_lin = BANK_MAX'(rest >> row_bits_i) & bank_msk;
  assign bank_il  = BANK_MAX'(rest) & bank_msk;
  assign row_il   = ROW_MAX'(rest >> bank_bits_i) & row_msk;

  assign row_o  = interleave_i ? row_il  : row_lin;
  assign bank_o = interleave_i ? bank_il : bank_lin;

  always_comb begin
    assert_col_width_R11: assert ((32'(col_o) >> col_bits_i) == 0);
  end

endmodule

// File: rtl/dram_addr_map.sv
module dram_addr_map
  import dram_map_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned BYTE_BITS = 2,
  parameter int unsigned BASE_W    = 8,
  parameter int unsigned COL_MIN   = 7,
  parameter int unsigned COL_MAX   = 10,
  parameter int unsigned ROW_MIN   = 12,
  parameter int unsigned ROW_MAX   = 15,
  parameter int unsigned BANK_MAX  = 3,
  parameter logic [31:0] RST_CFG   = 32'h28F8_0312
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [31:0]         cfg_wdata_i,
  input  logic                req_valid_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  output logic                out_valid_o,
  output logic                hit_o,
  output logic [BANK_MAX-1:0] bank_o,
  output logic [ROW_MAX-1:0]  row_o,
  output logic [COL_MAX-1:0]  col_o,
  output logic                cfg_error_o
);

  localparam int unsigned CB_W = $clog2(COL_MAX + 1);
  localparam int unsigned RB_W = $clog2(ROW_MAX + 1);
  localparam int unsigned BB_W = $clog2(BANK_MAX + 1);

  map_cfg_t            cfg;
  logic [CB_W-1:0]     col_bits;
  logic [RB_W-1:0]     row_bits;
  logic [BB_W-1:0]     bank_bits;
  logic                interleave, cfg_err, match;
  logic [BANK_MAX-1:0] bank_d;
  logic [ROW_MAX-1:0]  row_d;
  logic [COL_MAX-1:0]  col_d;

  dram_map_cfg #(
    .RST_CFG(RST_CFG), .COL_MIN(COL_MIN), .ROW_MIN(ROW_MIN),
    .CB_W(CB_W), .RB_W(RB_W), .BB_W(BB_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .cfg_o       (cfg),
    .col_bits_o  (col_bits),
    .row_bits_o  (row_bits),
    .bank_bits_o (bank_bits),
    .interleave_o(interleave),
    .err_o       (cfg_err)
  );

  dram_map_match #(.BASE_W(BASE_W)) u_match (
    .addr_hi_i(req_addr_i[ADDR_W-1 -: BASE_W]),
    .base_i   (cfg.base),
    .mask_i   (cfg.mask),
    .hit_o    (match)
  );

  dram_map_slice #(
    .ADDR_W(ADDR_W), .BYTE_BITS(BYTE_BITS), .BASE_W(BASE_W),
    .COL_MAX(COL_MAX), .ROW_MAX(ROW_MAX), .BANK_MAX(BANK_MAX),
    .CB_W(CB_W), .RB_W(RB_W), .BB_W(BB_W)
  ) u_slice (
    .addr_i      (req_addr_i),
    .mask_i      (cfg.mask),
    .col_bits_i  (col_bits),
    .row_bits_i  (row_bits),
    .bank_bits_i (bank_bits),
    .interleave_i(interleave),
    .bank_o      (bank_d),
    .row_o       (row_d),
    .col_o       (col_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      bank_o      <= '0;
      row_o       <= '0;
      col_o       <= '0;
    end else if (req_valid_i) begin
      out_valid_o <= 1'b1;
      hit_o       <= match & ~cfg_err;
      bank_o      <= cfg_err ? '0 : bank_d;
      row_o       <= cfg_err ? '0 : row_d;
      col_o       <= cfg_err ? '0 : col_d;
    end else begin
      out_valid_o <= 1'b0;
      hit_o       <= 1'b0;
    end
  end

  assign cfg_error_o = cfg_err;

  assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> out_valid_o);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!out_valid_o && !hit_o && $stable(row_o) && $stable(col_o) && $stable(bank_o)));

  assert_err_blocks_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_error_o) |=> (!hit_o && bank_o == '0 && row_o == '0 && col_o == '0));

  assert_hit_needs_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> out_valid_o);

endmodule

// File: tb/tb_dram_addr_map.sv
module tb_dram_addr_map;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        out_valid, hit, cfg_error;
  logic [2:0]  bank;
  logic [14:0] row;
  logic [9:0]  col;

  dram_addr_map dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .out_valid_o(out_valid), .hit_o(hit),
    .bank_o(bank), .row_o(row), .col_o(col),
    .cfg_error_o(cfg_error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state
  logic [31:0] m_cfg = 32'h28F8_0312;
  bit          e_valid = 0, e_hit = 0;
  longint      e_bank = 0, e_row = 0, e_col = 0;
  string       e_tag = "R9";

  task automatic chk(string tag, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit m_err(logic [31:0] c);
    return (c[15:12] > 1) || (c[11:8] > 3) || (c[7:4] > 3) || (c[3:0] > 3);
  endfunction

  task automatic model(input logic [31:0] c, input logic [31:0] a,
                       output bit h, output longint bk, output longint rw, output longint cl);
    longint off, rest;
    int cw, rwd, bw;
    if (m_err(c)) begin
      h = 0; bk = 0; rw = 0; cl = 0;
      return;
    end
    h   = ((a[31:24] & c[23:16]) == c[31:24]);
    off = longint'({a[31:24] & ~c[23:16], a[23:0]}) >> 2;
    cw  = 7 + int'(c[11:8]);
    rwd = 12 + int'(c[7:4]);
    bw  = int'(c[3:0]);
    cl   = off & ((64'd1 << cw) - 1);
    rest = off >> cw;
    if (c[15:12] == 0) begin
      rw = rest & ((64'd1 << rwd) - 1);
      bk = (rest >> rwd) & ((64'd1 << bw) - 1);
    end else begin
      bk = rest & ((64'd1 << bw) - 1);
      rw = (rest >> bw) & ((64'd1 << rwd) - 1);
    end
  endtask

  // called at a falling edge: compare, then drive the next cycle
  task automatic step(bit we, logic [31:0] wd, bit v, logic [31:0] a, string tag);
    bit h; longint bk, rw, cl;
    chk("R8", "cfg_error", longint'(cfg_error), longint'(m_err(m_cfg)));
    chk("R9", "out_valid", longint'(out_valid), longint'(e_valid));
    chk(e_valid ? "R2" : "R9", "hit", longint'(hit), longint'(e_hit));
    chk(e_tag, "bank", longint'(bank), e_bank);
    chk(e_tag, "row",  longint'(row),  e_row);
    chk(e_tag, "col",  longint'(col),  e_col);
    e_valid = v;
    if (v) begin
      model(m_cfg, a, h, bk, rw, cl);   // R10: old word used
      e_hit = h; e_bank = bk; e_row = rw; e_col = cl; e_tag = tag;
    end else begin
      e_hit = 0;
    end
    if (we) m_cfg = wd;
    cfg_we = we; cfg_wdata = wd; req_valid = v; req_addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic req(logic [31:0] a, string tag);
    step(0, '0, 1, a, tag);
  endtask

  task automatic wr(logic [31:0] wd, string tag);
    step(1, wd, 0, '0, tag);
  endtask

  function automatic logic [31:0] mk(logic [7:0] b, logic [7:0] m, logic [3:0] mp,
                                     logic [3:0] c, logic [3:0] r, logic [3:0] k);
    return {b, m, mp, c, r, k};
  endfunction

  initial begin : watchdog
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9/R1: quiet outputs and legal word during reset
    chk("R9", "out_valid in reset", longint'(out_valid), 0);
    chk("R9", "hit in reset", longint'(hit), 0);
    chk("R1", "cfg_error in reset", longint'(cfg_error), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset window and linear layout
    req(32'h2800_0000, "R1");
    req(32'h2FFF_FFFC, "R1");
    req(32'h2ABC_DEF7, "R4");
    req(32'h3000_0000, "R1");
    req(32'h27FF_FFFC, "R1");
    step(0, '0, 0, 32'h2FFF_FFFC, "R9");
    step(0, '0, 0, '0, "R9");
    req(32'h2C00_1234, "R5");

    // R10: write and request in the same cycle
    step(1, mk(8'h40, 8'hF0, 4'd1, 4'd0, 4'd0, 4'd3), 1, 32'h4FFF_FFFC, "R10");
    req(32'h4FFF_FFFC, "R6");
    req(32'h4123_4567, "R6");
    req(32'h2800_0000, "R2");

    // R3: single mask bit, widest geometry
    wr(mk(8'h80, 8'h80, 4'd0, 4'd3, 4'd3, 4'd3), "R3");
    req(32'hFFFF_FFFC, "R3");
    req(32'h7FFF_FFFC, "R3");
    // R2: base bit outside mask never hits
    wr(mk(8'h81, 8'h80, 4'd1, 4'd3, 4'd3, 4'd3), "R2");
    req(32'h81FF_FFFC, "R2");
    req(32'hFFFF_FFFC, "R2");

    // R8: reserved codes
    wr(mk(8'h28, 8'hF8, 4'd2, 4'd3, 4'd1, 4'd2), "R8");
    req(32'h2FFF_FFFC, "R8");
    wr(mk(8'h28, 8'hF8, 4'd0, 4'd4, 4'd1, 4'd2), "R8");
    req(32'h2FFF_FFFC, "R8");
    wr(mk(8'h28, 8'hF8, 4'd1, 4'd3, 4'hF, 4'd2), "R8");
    req(32'h2FFF_FFFC, "R8");
    wr(mk(8'h28, 8'hF8, 4'd0, 4'd3, 4'd1, 4'd5), "R8");
    req(32'h2FFF_FFFC, "R8");

    // R7/R4/R11: sweep every legal geometry and order
    for (int mp = 0; mp < 2; mp++)
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          for (int k = 0; k < 4; k++) begin
            wr(mk(8'h00, 8'hC0, 4'(mp), 4'(c), 4'(r), 4'(k)), "R7");
            req(32'h3FFF_FFFF, "R11");
            req(32'h2AAA_AAA8, mp == 0 ? "R5" : "R6");
            req(32'h1555_5554, "R7");
          end

    // mixed random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] a, w;
      bit we, v;
      a  = $urandom;
      we = ($urandom % 10) == 0;
      v  = ($urandom % 4) != 0;
      w  = {8'($urandom), 8'($urandom), 4'($urandom % 3), 4'($urandom % 5),
            4'($urandom % 5), 4'($urandom % 5)};
      if (($urandom % 3) == 0) a[31:24] = w[31:24];
      step(we, w, v, a, "R10");
    end
    step(0, '0, 0, '0, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule